// File: doc/BRIEF.md
# Masked-Write PHY Control Register Bank

This block holds the static configuration of a storage-card PHY as a small set of control registers on a simple memory-mapped bus. Each register stores 16 bits. A write word carries two halves. The lower half is the new data, and the upper half is a per-bit enable for that data. A bit of the low half changes only when its enable bit is set. Software can therefore update a single field, such as the DLL enable, without first reading the register back and merging.

The stored bits are decoded into named control outputs: power-up, DLL enable, drive strength, DLL frequency band, output tap delay and strobe pull-down. These outputs come straight from flops. A separate read-only status word shows two live input flags, calibration complete and DLL locked. Reads are registered and return one cycle after the read strobe.

Top module: `mmcphy_ctrl_bank`

## Requirements
- R1: On a write to a control register, stored bit x (0 to 15) takes write-data bit x only when write-data bit x+16 is 1. Otherwise bit x keeps its old value.
- R2: The upper 16 bits of any value read from a control register are always zero.
- R3: After reset, control register 0 holds 0x0200 (tap-delay select 4). Every other control register holds 0. All control outputs are low, except tap_sel_o, which is 4.
- R4: Control register 6 at offset 0x18 drives the outputs as follows. Bit 0 drives pwr_up_o (1 = powered). Bit 1 drives dll_en_o. Bits 6:4 drive drive_code_o, with 0 = 50 ohm, 1 = 33 ohm, 2 = 66 ohm, 3 = 100 ohm and 4 = 40 ohm.
- R5: Control register 0 at offset 0x00 drives the outputs as follows. Bits 13:12 drive freq_sel_o, with 0 = 200 MHz, 1 = 50 MHz, 2 = 100 MHz and 3 = 150 MHz. Bit 11 drives tap_en_o. Bits 10:7 drive tap_sel_o.
- R6: Bit 9 of control register 2 at offset 0x08 drives strobe_pd_o.
- R7: Read data appears on the cycle after the cycle in which bus_rd is sampled high. While bus_rd is low, bus_rdata holds its last value.
- R8: A read of offset 0x20 returns cal_done_i in bit 6 and dll_lock_i in bit 5, as sampled in the read cycle. All other bits are zero. Writes to 0x20 change nothing.
- R9: Control registers sit at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18. Every other offset, including 0x1C, 0x24 and non-word-aligned offsets, ignores writes and reads as zero.
- R10: If a read and a write reach the same register in one cycle, the read returns the contents from before the write.
- R11: A write to one control register leaves the other six unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write enables in [31:16], data in [15:0] |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| cal_done_i | input | 1 | Calibration complete flag |
| dll_lock_i | input | 1 | DLL locked flag |
| pwr_up_o | output | 1 | Analog power-up control |
| dll_en_o | output | 1 | DLL enable |
| drive_code_o | output | 3 | Output drive strength code |
| freq_sel_o | output | 2 | DLL frequency band |
| tap_en_o | output | 1 | Output tap delay enable |
| tap_sel_o | output | 4 | Output tap delay select |
| strobe_pd_o | output | 1 | Strobe line pull-down enable |

## Verification
The assertions check on every cycle that a write with an all-zero enable half leaves a register untouched. They also check that a register is frozen when no write selects it, and that read data holds between reads. Further per-cycle checks cover that control reads and unmapped reads return zero in the upper half and in full respectively, and that the status bits follow the inputs with one cycle of delay. Some behaviour only the directed scenarios can show: the exact merge of partial enables, the decoded field positions and their code values, the reset contents, read-before-write ordering and aliasing between offsets.

// File: rtl/mmcphy_bank_pkg.sv
package mmcphy_bank_pkg;
  localparam int DATA_W   = 32;
  localparam int HALF_W   = DATA_W / 2;
  localparam int NUM_CTRL = 7;
  localparam int ADDR_W   = 8;
  localparam int STAT_OFF = 32'h20;

  // field positions
  localparam int PWR_BIT      = 0;
  localparam int DLLEN_BIT    = 1;
  localparam int DRV_LSB      = 4;
  localparam int DRV_W        = 3;
  localparam int TAPSEL_LSB   = 7;
  localparam int TAPSEL_W     = 4;
  localparam int TAPEN_BIT    = 11;
  localparam int FREQ_LSB     = 12;
  localparam int FREQ_W       = 2;
  localparam int STRB_BIT     = 9;
  localparam int ST_CAL_BIT   = 6;
  localparam int ST_LOCK_BIT  = 5;

  localparam int REG_TIMING   = 0;
  localparam int REG_STROBE   = 2;
  localparam int REG_POWER    = 6;

  typedef enum logic [2:0] {
    DRV_50  = 3'd0,
    DRV_33  = 3'd1,
    DRV_66  = 3'd2,
    DRV_100 = 3'd3,
    DRV_40  = 3'd4
  } drive_code_e;

  typedef enum logic [1:0] {
    FREQ_200 = 2'd0,
    FREQ_50  = 2'd1,
    FREQ_100 = 2'd2,
    FREQ_150 = 2'd3
  } freq_band_e;
endpackage

// File: rtl/mask_reg.sv
module mask_reg #(
  parameter int W = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wen,
  input  logic [W-1:0] wval,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else if (we) q <= (q & ~wen) | (wval & wen);
  end

  // R1: a write with no enabled bits changes nothing
  assert_zero_mask_keeps_R1: assert property (@(posedge clk) disable iff (rst)
    (we && wen == '0) |=> $stable(q));
  // R11: an unselected register is frozen
  assert_unselected_frozen_R11: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
endmodule

// File: rtl/bank_decode.sv
module bank_decode #(
  parameter int ADDR_W   = 8,
  parameter int NUM_CTRL = 7,
  parameter int STAT_OFF = 32'h20
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_CTRL-1:0] ctrl_hit,
  output logic                stat_hit
);
  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_hit
    assign ctrl_hit[i] = (addr == ADDR_W'(i * 4));
  end
  assign stat_hit = (addr == ADDR_W'(STAT_OFF));

  // R9: at most one target selected for any offset
  always_comb begin
    assert_single_target_R9: assert ($onehot0({ctrl_hit, stat_hit}));
  end
endmodule

// File: rtl/bank_read.sv
module bank_read #(
  parameter int NUM_CTRL = 7,
  parameter int HALF_W   = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           rd,
  input  logic [NUM_CTRL-1:0]            ctrl_hit,
  input  logic                           stat_hit,
  input  logic [NUM_CTRL-1:0][HALF_W-1:0] regs,
  input  logic [HALF_W-1:0]              stat_word,
  output logic [2*HALF_W-1:0]            rdata
);
  logic [HALF_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_CTRL; i++)
      if (ctrl_hit[i]) sel = sel | regs[i];
    if (stat_hit) sel = sel | stat_word;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd) rdata <= {{HALF_W{1'b0}}, sel};
  end

  // R7: data holds between reads
  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));
  // R2: upper half always zero after a read
  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    rd |=> rdata[2*HALF_W-1:HALF_W] == '0);
  // R9: unmapped reads return zero
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd && ctrl_hit == '0 && !stat_hit) |=> rdata == '0);
endmodule

// File: rtl/mmcphy_ctrl_bank.sv
module mmcphy_ctrl_bank
  import mmcphy_bank_pkg::*;
#(
  parameter int          AW          = ADDR_W,
  parameter logic [3:0]  TAP_SEL_RST = 4'd4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  input  logic          bus_rd,
  output logic [31:0]   bus_rdata,
  input  logic          cal_done_i,
  input  logic          dll_lock_i,
  output logic          pwr_up_o,
  output logic          dll_en_o,
  output logic [2:0]    drive_code_o,
  output logic [1:0]    freq_sel_o,
  output logic          tap_en_o,
  output logic [3:0]    tap_sel_o,
  output logic          strobe_pd_o
);
  localparam logic [HALF_W-1:0] TIMING_RST = HALF_W'(TAP_SEL_RST) << TAPSEL_LSB;

  logic [NUM_CTRL-1:0]             ctrl_hit;
  logic                            stat_hit;
  logic [NUM_CTRL-1:0][HALF_W-1:0] regs;
  logic [HALF_W-1:0]               stat_word;

  bank_decode #(.ADDR_W(AW), .NUM_CTRL(NUM_CTRL), .STAT_OFF(STAT_OFF)) u_dec (
    .addr(bus_addr), .ctrl_hit(ctrl_hit), .stat_hit(stat_hit));

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_reg
    localparam logic [HALF_W-1:0] RV = (i == REG_TIMING) ? TIMING_RST : '0;
    mask_reg #(.W(HALF_W), .RST_VAL(RV)) u_reg (
      .clk (clk),
      .rst (rst),
      .we  (bus_wr && ctrl_hit[i]),
      .wen (bus_wdata[DATA_W-1:HALF_W]),
      .wval(bus_wdata[HALF_W-1:0]),
      .q   (regs[i]));
  end

  always_comb begin
    stat_word = '0;
    stat_word[ST_CAL_BIT]  = cal_done_i;
    stat_word[ST_LOCK_BIT] = dll_lock_i;
  end

  bank_read #(.NUM_CTRL(NUM_CTRL), .HALF_W(HALF_W)) u_rd (
    .clk(clk), .rst(rst), .rd(bus_rd), .ctrl_hit(ctrl_hit), .stat_hit(stat_hit),
    .regs(regs), .stat_word(stat_word), .rdata(bus_rdata));

  assign pwr_up_o     = regs[REG_POWER][PWR_BIT];
  assign dll_en_o     = regs[REG_POWER][DLLEN_BIT];
  assign drive_code_o = regs[REG_POWER][DRV_LSB +: DRV_W];
  assign freq_sel_o   = regs[REG_TIMING][FREQ_LSB +: FREQ_W];
  assign tap_en_o     = regs[REG_TIMING][TAPEN_BIT];
  assign tap_sel_o    = regs[REG_TIMING][TAPSEL_LSB +: TAPSEL_W];
  assign strobe_pd_o  = regs[REG_STROBE][STRB_BIT];

  // R4: enabled power bit write reaches the output next cycle
  assert_pwr_follows_write_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(REG_POWER * 4) && bus_wdata[HALF_W + PWR_BIT])
      |=> pwr_up_o == $past(bus_wdata[PWR_BIT]));
  // R8: status bits follow inputs with one cycle of read latency
  assert_status_bits_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == AW'(STAT_OFF))
      |=> (bus_rdata[ST_CAL_BIT] == $past(cal_done_i)) &&
          (bus_rdata[ST_LOCK_BIT] == $past(dll_lock_i)));
endmodule

// File: tb/mmcphy_ctrl_bank_bench.sv
module mmcphy_ctrl_bank_bench;
  logic        clk = 0;
  logic        rst = 1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 0;
  logic [31:0] bus_rdata;
  logic        cal_done_i = 0, dll_lock_i = 0;
  logic        pwr_up_o, dll_en_o, tap_en_o, strobe_pd_o;
  logic [2:0]  drive_code_o;
  logic [1:0]  freq_sel_o;
  logic [3:0]  tap_sel_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] model [7];

  always #2.5 clk = ~clk;

  mmcphy_ctrl_bank u_mmcphy_ctrl_bank (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    if (a[1:0] == 0 && a < 8'h1C) begin
      model[a>>2] = (model[a>>2] & ~d[31:16]) | (d[15:0] & d[31:16]);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; v = bus_rdata;
  endtask

  task automatic verify_all(string req);
    logic [31:0] v;
    for (int i = 0; i < 7; i++) begin
      rd(8'(i*4), v);
      check(req, v, {16'h0, model[i]});
    end
  endtask

  task automatic t_reset;
    check("R3 pwr", pwr_up_o, 0);
    check("R3 dll", dll_en_o, 0);
    check("R3 drive", drive_code_o, 0);
    check("R3 tapsel", tap_sel_o, 4);
    check("R3 tapen", tap_en_o, 0);
    check("R3 freq", freq_sel_o, 0);
    check("R3 strobe", strobe_pd_o, 0);
    check("R3 rdata", bus_rdata, 0);
    verify_all("R3 contents");
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(8'h04, 32'hFFFF_A5A5); rd(8'h04, v); check("R1 full", v, 32'h0000_A5A5);
    wr(8'h04, 32'h00F0_0F0F); rd(8'h04, v); check("R1 partial", v, 32'h0000_A505);
    wr(8'h04, 32'h0000_FFFF); rd(8'h04, v); check("R1 nomask", v, 32'h0000_A505);
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, v); check("R2 upper zero", v, 32'h0000_FFFF);
  endtask

  task automatic t_power;
    wr(8'h18, 32'h0073_0033);
    check("R4 pwr", pwr_up_o, 1);
    check("R4 dll", dll_en_o, 1);
    check("R4 drive100", drive_code_o, 3);
    wr(8'h18, 32'h0070_0040);
    check("R4 drive40", drive_code_o, 4);
    check("R4 pwr kept", pwr_up_o, 1);
    wr(8'h18, 32'h0001_0000);
    check("R4 pwr off", pwr_up_o, 0);
    check("R4 dll kept", dll_en_o, 1);
  endtask

  task automatic t_timing;
    wr(8'h00, 32'h3F80_2C80);
    check("R5 freq", freq_sel_o, 2);
    check("R5 tapen", tap_en_o, 1);
    check("R5 tapsel", tap_sel_o, 9);
    wr(8'h00, 32'h3000_1000);
    check("R5 freq50", freq_sel_o, 1);
    check("R5 tapsel kept", tap_sel_o, 9);
  endtask

  task automatic t_strobe;
    logic [31:0] v;
    wr(8'h08, 32'h0200_0200);
    check("R6 strobe on", strobe_pd_o, 1);
    rd(8'h08, v); check("R6 readback", v, 32'h0000_0200);
  endtask

  task automatic t_latency;
    logic [31:0] v;
    rd(8'h04, v);
    @(negedge clk); bus_addr = 8'h0C; bus_rd = 1;
    check("R7 before edge", bus_rdata, 32'h0000_A505);
    @(negedge clk); bus_rd = 0;
    check("R7 after edge", bus_rdata, 32'h0000_FFFF);
    bus_addr = 8'h04;
    repeat (3) @(negedge clk);
    check("R7 hold", bus_rdata, 32'h0000_FFFF);
  endtask

  task automatic t_status;
    logic [31:0] v;
    cal_done_i = 1; dll_lock_i = 0;
    rd(8'h20, v); check("R8 cal", v, 32'h40);
    cal_done_i = 0; dll_lock_i = 1;
    rd(8'h20, v); check("R8 lock", v, 32'h20);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, v); check("R8 write ignored", v, 32'h20);
    verify_all("R8 no alias");
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, v); check("R9 0x1C", v, 0);
    wr(8'h24, 32'hFFFF_FFFF); rd(8'h24, v); check("R9 0x24", v, 0);
    wr(8'h01, 32'hFFFF_FFFF); rd(8'h01, v); check("R9 misaligned", v, 0);
    verify_all("R9 untouched");
  endtask

  task automatic t_rw_same;
    @(negedge clk); bus_addr = 8'h10; bus_wdata = 32'hFFFF_1234; bus_wr = 1; bus_rd = 1;
    @(negedge clk); bus_wr = 0; bus_rd = 0;
    check("R10 old data", bus_rdata, {16'h0, model[4]});
    model[4] = 16'h1234;
  endtask

  task automatic t_independent;
    wr(8'h14, 32'hFFFF_5A5A);
    verify_all("R11 isolation");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 7; i++) model[i] = 16'h0;
    model[0] = 16'h0200;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_mask();
    t_power();
    t_timing();
    t_strobe();
    t_latency();
    t_status();
    t_unmapped();
    t_rw_same();
    t_independent();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule